// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it reads the register numbers, valid bits and control bits held in the four inter-stage registers. From these it picks where each ALU operand in the execute stage comes from, detects a load whose result is needed one cycle too early, and squashes wrong-path work when a branch resolves taken in the memory stage. It also owns the program counter. The PC steps by 4, holds during a stall, or loads the branch target on a redirect.

Branches are predicted not taken, so fetch carries on in sequence. When the memory stage reports a taken branch, the three younger instructions are flushed: the one being fetched, the one in decode and the one in execute. The PC then jumps to the branch address plus 4 plus the sign-extended offset scaled by 4. A load-use dependence costs one bubble. After that bubble the load has reached write-back and the bypass from the write-back register supplies the operand.

All interfaces are plain control and status pins. The stage registers present their contents every cycle and the block answers combinationally, except for the PC, which is registered.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An execute-stage source register equal to the destination of a valid, register-writing instruction in the memory stage selects the memory-stage bypass, encoded 2'b10 on `fwd_a` (rs) or `fwd_b` (rt).
- R2: Otherwise, a match with a valid, register-writing instruction in write-back selects the write-back bypass, 2'b01. With no match the select is 2'b00 (register file).
- R3: When both the memory stage and write-back match the same source, the memory-stage bypass (2'b10) wins.
- R4: Register 0 never causes a bypass or a stall. Instructions whose valid bit or register-write bit is clear are never treated as producers.
- R5: A valid load in execute writing a nonzero register that a valid decode instruction reads (rs or rt with its use bit set) causes a stall: `pc_en`=0, `ifid_en`=0, `idex_bubble`=1.
- R6: A load-use stall lasts one cycle. Once the load has moved on, the consumer receives its operand through the write-back bypass.
- R7: A valid taken branch in the memory stage drives `redirect`, `flush_ifid`, `flush_idex` and `flush_exmem` high in that same cycle.
- R8: On a redirect the PC takes the value branch PC + 4 + (sign-extended 16-bit offset shifted left by 2) at the next clock edge, modulo 2^ADDR_W.
- R9: A redirect overrides a stall in the same cycle: `pc_en`=1, `ifid_en`=1, `idex_bubble`=0.
- R10: After reset the PC equals RESET_PC. It advances by 4 on each clock edge with neither stall nor redirect, and holds its value while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid | input | 1 | Decode-stage instruction is valid |
| id_rs | input | REG_W | Decode-stage first source register |
| id_rt | input | REG_W | Decode-stage second source register |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| ex_valid | input | 1 | Execute-stage instruction is valid |
| ex_rs | input | REG_W | Execute-stage first source register |
| ex_rt | input | REG_W | Execute-stage second source register |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory-stage instruction is valid |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_is_branch | input | 1 | Memory instruction is a conditional branch |
| mem_br_taken | input | 1 | Branch condition evaluated true |
| mem_br_pc | input | ADDR_W | Address of the branch instruction |
| mem_br_imm | input | IMM_W | Branch offset in words, signed |
| wb_valid | input | 1 | Write-back instruction is valid |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| wb_rd | input | REG_W | Write-back destination register |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_en | output | 1 | PC register update enable |
| ifid_en | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Load a nop into the decode/execute register |
| flush_ifid | output | 1 | Squash the instruction entering decode |
| flush_idex | output | 1 | Squash the instruction entering execute |
| flush_exmem | output | 1 | Squash the instruction entering memory |
| redirect | output | 1 | Taken branch resolved; PC loads target |
| pc_q | output | ADDR_W | Current fetch address |

## Verification
The assertions assume that stage inputs are known and settled before each rising edge, and that a stalled decode instruction stays in place while the one ahead of it drains. They also assume that target arithmetic wraps at the PC width, and that `mem_br_taken` is meaningful only together with `mem_is_branch`. The stimulus draws register numbers from a narrow range so that matches, register-0 cases and double matches happen often. Valid and write bits are set at random so that non-producers appear regularly, and branch offsets cover both signs. Directed sequences replay a load followed by its consumer across the bubble, and a redirect that lands on the same cycle as a load-use stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_bypass_mux.sv
module hzd_bypass_mux
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             mem_valid,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_wr_en,
  input  logic [REG_W-1:0] wb_rd,
  output fwd_sel_e         sel
);
  logic src_live, hit_mem, hit_wb;

  // register 0 is hard-wired, never a bypass target
  assign src_live = |src;
  assign hit_mem  = src_live && mem_valid && mem_wr_en && (mem_rd == src);
  assign hit_wb   = src_live && wb_valid && wb_wr_en && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel = FWD_MEM; // newest producer first
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_W = 5
) (
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic             ex_valid,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_rd,
  output logic             stall
);
  logic load_prod, dep_rs, dep_rt;

  assign load_prod = ex_valid && ex_is_load && ex_wr_en && (|ex_rd);
  assign dep_rs    = id_use_rs && (id_rs == ex_rd);
  assign dep_rt    = id_use_rt && (id_rt == ex_rd);
  assign stall     = id_valid && load_prod && (dep_rs || dep_rt);
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              mem_valid,
  input  logic              mem_is_branch,
  input  logic              mem_br_taken,
  input  logic [ADDR_W-1:0] mem_br_pc,
  input  logic [IMM_W-1:0]  mem_br_imm,
  output logic              redirect,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;
  logic [ADDR_W-1:0] offset;

  assign offset   = {{EXT_W{mem_br_imm[IMM_W-1]}}, mem_br_imm, 2'b00};
  assign target   = mem_br_pc + ADDR_W'(4) + offset;
  assign redirect = mem_valid && mem_is_branch && mem_br_taken;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzd_pkg::*;
#(
  parameter int              REG_W    = 5,
  parameter int              ADDR_W   = 32,
  parameter int              IMM_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic              ex_valid,
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic              ex_wr_en,
  input  logic [REG_W-1:0]  ex_rd,
  input  logic              ex_is_load,
  input  logic              mem_valid,
  input  logic              mem_wr_en,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic              mem_is_branch,
  input  logic              mem_br_taken,
  input  logic [ADDR_W-1:0] mem_br_pc,
  input  logic [IMM_W-1:0]  mem_br_imm,
  input  logic              wb_valid,
  input  logic              wb_wr_en,
  input  logic [REG_W-1:0]  wb_rd,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              idex_bubble,
  output logic              flush_ifid,
  output logic              flush_idex,
  output logic              flush_exmem,
  output logic              redirect,
  output logic [ADDR_W-1:0] pc_q
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] ex_src;
  fwd_sel_e                   src_sel [NSRC];
  logic                       stall;
  logic [ADDR_W-1:0]          br_target;

  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;

  for (genvar g = 0; g < NSRC; g++) begin : g_bypass
    hzd_bypass_mux #(.REG_W(REG_W)) i_mux (
      .src       (ex_src[g]),
      .mem_valid (mem_valid),
      .mem_wr_en (mem_wr_en),
      .mem_rd    (mem_rd),
      .wb_valid  (wb_valid),
      .wb_wr_en  (wb_wr_en),
      .wb_rd     (wb_rd),
      .sel       (src_sel[g])
    );
  end

  assign fwd_a = src_sel[0];
  assign fwd_b = src_sel[1];

  hzd_load_use #(.REG_W(REG_W)) i_load_use (
    .id_valid   (id_valid),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_use_rs  (id_use_rs),
    .id_use_rt  (id_use_rt),
    .ex_valid   (ex_valid),
    .ex_wr_en   (ex_wr_en),
    .ex_is_load (ex_is_load),
    .ex_rd      (ex_rd),
    .stall      (stall)
  );

  hzd_redirect #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) i_redirect (
    .mem_valid     (mem_valid),
    .mem_is_branch (mem_is_branch),
    .mem_br_taken  (mem_br_taken),
    .mem_br_pc     (mem_br_pc),
    .mem_br_imm    (mem_br_imm),
    .redirect      (redirect),
    .target        (br_target)
  );

  // squash wins over a stall: the stalled consumer is on the wrong path
  assign pc_en       = redirect || !stall;
  assign ifid_en     = pc_en;
  assign idex_bubble = stall && !redirect;
  assign flush_ifid  = redirect;
  assign flush_idex  = redirect;
  assign flush_exmem = redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (redirect) pc_q <= br_target;
    else if (pc_en)    pc_q <= pc_q + ADDR_W'(4);
  end
endmodule

// File: rtl/pipe_hazard_checker.sv
module pipe_hazard_checker #(
  parameter int REG_W  = 5,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  ex_rs,
  input logic [REG_W-1:0]  ex_rt,
  input logic              mem_valid,
  input logic              mem_wr_en,
  input logic [REG_W-1:0]  mem_rd,
  input logic              mem_is_branch,
  input logic              mem_br_taken,
  input logic [ADDR_W-1:0] mem_br_pc,
  input logic [IMM_W-1:0]  mem_br_imm,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              pc_en,
  input logic              ifid_en,
  input logic              idex_bubble,
  input logic              flush_ifid,
  input logic              flush_idex,
  input logic              flush_exmem,
  input logic              redirect,
  input logic [ADDR_W-1:0] pc_q
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  a_r4_zero_src_a: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00) |-> (ex_rs != '0));
  a_r4_zero_src_b: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b != 2'b00) |-> (ex_rt != '0));
  a_r3_newest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b01) |-> !(mem_valid && mem_wr_en && mem_rd == ex_rs));
  a_r5_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_en && !ifid_en));
  a_r7_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_is_branch && mem_br_taken) |->
      (flush_ifid && flush_idex && flush_exmem));
  a_r9_flush_over_stall: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (pc_en && ifid_en && !idex_bubble));
  a_r8_target_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> pc_q == $past(mem_br_pc + ADDR_W'(4) +
      {{EXT_W{mem_br_imm[IMM_W-1]}}, mem_br_imm, 2'b00}));
  a_r10_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> $stable(pc_q));
  a_r10_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en && !redirect) |=> pc_q == $past(pc_q) + ADDR_W'(4));
endmodule

bind pipe_hazard_unit pipe_hazard_checker #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)
) i_chk (.*);

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;
  localparam int REG_W = 5;
  localparam int ADDR_W = 32;
  localparam int IMM_W = 16;
  localparam logic [ADDR_W-1:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n;
  logic id_valid, id_use_rs, id_use_rt;
  logic [REG_W-1:0] id_rs, id_rt;
  logic ex_valid, ex_wr_en, ex_is_load;
  logic [REG_W-1:0] ex_rs, ex_rt, ex_rd;
  logic mem_valid, mem_wr_en, mem_is_branch, mem_br_taken;
  logic [REG_W-1:0] mem_rd;
  logic [ADDR_W-1:0] mem_br_pc;
  logic [IMM_W-1:0] mem_br_imm;
  logic wb_valid, wb_wr_en;
  logic [REG_W-1:0] wb_rd;
  logic [1:0] fwd_a, fwd_b;
  logic pc_en, ifid_en, idex_bubble, flush_ifid, flush_idex, flush_exmem, redirect;
  logic [ADDR_W-1:0] pc_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [ADDR_W-1:0] exp_pc;

  always #4 clk = ~clk;

  pipe_hazard_unit #(.REG_W(REG_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W), .RESET_PC(RST_PC))
  i_pipe_hazard_unit (.*);

  task automatic chk(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic [REG_W-1:0] s);
    if (s == 0) return 2'b00;                                         // R4
    if (mem_valid && mem_wr_en && mem_rd == s) return 2'b10;          // R1, R3
    if (wb_valid && wb_wr_en && wb_rd == s) return 2'b01;             // R2
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    if (!(id_valid && ex_valid && ex_is_load && ex_wr_en && ex_rd != 0)) return 1'b0;
    return (id_use_rs && id_rs == ex_rd) || (id_use_rt && id_rt == ex_rd);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_target();
    logic signed [ADDR_W-1:0] off;
    off = ADDR_W'($signed(mem_br_imm)) * 4;
    return mem_br_pc + 4 + off;
  endfunction

  task automatic clear_inputs();
    id_valid = 0; id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0;
    ex_valid = 0; ex_rs = 0; ex_rt = 0; ex_wr_en = 0; ex_rd = 0; ex_is_load = 0;
    mem_valid = 0; mem_wr_en = 0; mem_rd = 0; mem_is_branch = 0; mem_br_taken = 0;
    mem_br_pc = 0; mem_br_imm = 0;
    wb_valid = 0; wb_wr_en = 0; wb_rd = 0;
  endtask

  // inputs were set just after a falling edge; check, then move to the next one
  task automatic step();
    logic st, rd;
    #1;
    st = exp_stall();
    rd = mem_valid && mem_is_branch && mem_br_taken;
    chk("R10 pc", pc_q, exp_pc);
    chk("R1/R2/R3/R4 fwd_a", 32'(fwd_a), 32'(exp_sel(ex_rs)));
    chk("R1/R2/R3/R4 fwd_b", 32'(fwd_b), 32'(exp_sel(ex_rt)));
    chk("R5/R9 pc_en", 32'(pc_en), 32'(rd || !st));
    chk("R5/R9 ifid_en", 32'(ifid_en), 32'(rd || !st));
    chk("R5/R6/R9 idex_bubble", 32'(idex_bubble), 32'(st && !rd));
    chk("R7 redirect", 32'(redirect), 32'(rd));
    chk("R7 flushes", 32'({flush_ifid, flush_idex, flush_exmem}), 32'({3{rd}}));
    if (rd) exp_pc = exp_target();       // R8
    else if (!st) exp_pc = exp_pc + 4;   // R10
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240);
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset pc", pc_q, RST_PC);
    exp_pc = RST_PC;
    rst_n = 1;

    // R3: both later stages write r3
    ex_rs = 3; ex_rt = 5; ex_valid = 1;
    mem_valid = 1; mem_wr_en = 1; mem_rd = 3;
    wb_valid = 1; wb_wr_en = 1; wb_rd = 3;
    step();
    // R4: register 0 and non-writing producer
    clear_inputs();
    ex_valid = 1; ex_rs = 0; ex_rt = 6;
    mem_valid = 1; mem_wr_en = 1; mem_rd = 0;
    wb_valid = 1; wb_wr_en = 0; wb_rd = 6;
    id_valid = 1; id_use_rs = 1; id_rs = 0;
    step();
    ex_is_load = 1; ex_wr_en = 1; ex_rd = 0;   // R4: load to r0 never stalls
    step();
    // R5/R6: load r4, consumer reads r4
    clear_inputs();
    ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 4;
    id_valid = 1; id_use_rt = 1; id_rt = 4;
    step();
    clear_inputs();                              // bubble in EX, load in MEM
    mem_valid = 1; mem_wr_en = 1; mem_rd = 4;
    id_valid = 1; id_use_rt = 1; id_rt = 4;
    step();
    clear_inputs();                              // consumer in EX, load in WB
    ex_valid = 1; ex_rt = 4;
    wb_valid = 1; wb_wr_en = 1; wb_rd = 4;
    step();
    // R9: redirect and load-use together; R8 negative offset
    clear_inputs();
    ex_valid = 1; ex_is_load = 1; ex_wr_en = 1; ex_rd = 7;
    id_valid = 1; id_use_rs = 1; id_rs = 7;
    mem_valid = 1; mem_is_branch = 1; mem_br_taken = 1;
    mem_br_pc = 32'h0000_0100; mem_br_imm = 16'hFFFC;
    step();
    clear_inputs();
    chk("R8 negative offset target", pc_q, 32'h0000_00F4);
    // R8 positive offset
    mem_valid = 1; mem_is_branch = 1; mem_br_taken = 1;
    mem_br_pc = 32'h0000_2000; mem_br_imm = 16'h0010;
    step();
    clear_inputs();
    chk("R8 positive offset target", pc_q, 32'h0000_2044);
    // untaken branch does nothing special
    mem_valid = 1; mem_is_branch = 1; mem_br_taken = 0;
    step();

    for (int i = 0; i < 2000; i++) begin
      id_valid = ($urandom % 4) != 0;
      id_rs = REG_W'($urandom % 4); id_rt = REG_W'($urandom % 4);
      id_use_rs = $urandom % 2; id_use_rt = $urandom % 2;
      ex_valid = ($urandom % 4) != 0;
      ex_rs = REG_W'($urandom % 4); ex_rt = REG_W'($urandom % 4);
      ex_rd = REG_W'($urandom % 4);
      ex_wr_en = $urandom % 2; ex_is_load = ($urandom % 3) == 0;
      mem_valid = ($urandom % 4) != 0; mem_wr_en = $urandom % 2;
      mem_rd = REG_W'($urandom % 4);
      mem_is_branch = ($urandom % 5) == 0; mem_br_taken = $urandom % 2;
      mem_br_pc = {$urandom, 2'b00} & 32'hFFFF_FFFC;
      mem_br_imm = IMM_W'($urandom);
      wb_valid = ($urandom % 4) != 0; wb_wr_en = $urandom % 2;
      wb_rd = REG_W'($urandom % 4);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule